// File: doc/BRIEF.md
# Three-Operand Signed ALU

This block is the execute unit for the arithmetic, logic, shift and compare instructions of a small 32-bit CPU. Each cycle it takes an 8-bit opcode, two signed register operands (`src_a`, `src_b`) and a 32-bit immediate (`imm`). It returns a result word, a divide-by-zero flag and an illegal-opcode flag. Most operations fold the immediate into the second register operand. One encoding therefore covers the register form, the immediate form and the mixed form. The assembler gets the pure forms by passing the zero register or a zero immediate.

The datapath is combinational. The decoder maps the opcode to an internal operation kind. The kind selects one of three engines: sum/product, signed divider, and logic/shift/compare. With `REG_OUT = 1` (the default), an output stage holds the result and both flags, so they appear one clock after the inputs. With `REG_OUT = 0`, the outputs follow the inputs in the same cycle.

The block has no control state machine. The decoded operation kind takes the place of a state: one of fifteen legal kinds, or `OP_BAD` for any other opcode. The only sequential element is the output register.

Top module: `tri_alu`

## Requirements
- R1: Opcode 0x02 returns src_a + src_b + imm, wrapping modulo 2^32.
- R2: Opcode 0x17 returns src_a - (src_b + imm), wrapping modulo 2^32.
- R3: Opcode 0x03 returns the low 32 bits of src_a * src_b * imm.
- R4: Opcode 0x04 returns src_a / (src_b + imm) and opcode 0x05 returns imm / src_a. Both are signed and truncate toward zero. 0x80000000 divided by -1 returns 0x80000000.
- R5: Opcode 0x06 returns src_a % (src_b + imm) and opcode 0x07 returns imm % src_a. Both are signed, and the remainder takes the sign of the dividend.
- R6: For opcodes 0x04 to 0x07, a zero divisor gives result 0 with div_zero = 1. div_zero is 0 for every other case.
- R7: Opcode 0x0e returns 1 if src_a > src_b (signed), else 0. Opcode 0x0f returns 1 if src_a == src_b, else 0. Neither uses imm.
- R8: The logic opcodes are as follows, and opcodes 0x10 and 0x12 ignore imm:
  - 0x10 returns ~src_a.
  - 0x11 returns src_a | src_b | imm.
  - 0x12 returns src_a & src_b.
  - 0x13 returns src_a ^ (src_b + imm).
- R9: Opcode 0x15 shifts src_a left, and opcode 0x16 shifts src_a right arithmetically (sign fill). The shift amount is bits [4:0] of src_b + imm.
- R10: Any opcode not listed in R1 to R9 gives result 0 with bad_op = 1. bad_op is 0 for listed opcodes.
- R11: With REG_OUT = 1, outputs change only on the rising clock edge after their inputs, and an active-low reset clears result, div_zero and bad_op to 0.
- R12: div_zero and bad_op are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 8 | Operation code |
| src_a | input | 32 | First signed register operand |
| src_b | input | 32 | Second signed register operand |
| imm | input | 32 | Signed immediate |
| result | output | 32 | Operation result |
| div_zero | output | 1 | Division or remainder by zero |
| bad_op | output | 1 | Opcode not handled by this unit |

## Verification
A wrong decode or wrong engine selection shows up as a wrong `result` on the first output edge after the opcode is applied. With `REG_OUT = 1`, that is exactly one clock after the inputs. No state carries over between operations, so an error shows up on the operation that caused it and on no later one. An operand swap or missing sign handling in the divider shows only with negative or reversed operands, so the vectors include mixed-sign operands and both reversed forms. The flag outputs make a bad decode visible even when the result happens to be 0, because the flags must be set exactly for zero divisors and unlisted opcodes.

// File: rtl/tri_alu_pkg.sv
package tri_alu_pkg;

    localparam int OPW = 8;

    localparam logic [OPW-1:0] OPC_ADD  = 8'h02;
    localparam logic [OPW-1:0] OPC_MUL  = 8'h03;
    localparam logic [OPW-1:0] OPC_DIV  = 8'h04;
    localparam logic [OPW-1:0] OPC_DIVR = 8'h05;
    localparam logic [OPW-1:0] OPC_MOD  = 8'h06;
    localparam logic [OPW-1:0] OPC_MODR = 8'h07;
    localparam logic [OPW-1:0] OPC_GT   = 8'h0e;
    localparam logic [OPW-1:0] OPC_EQ   = 8'h0f;
    localparam logic [OPW-1:0] OPC_NOT  = 8'h10;
    localparam logic [OPW-1:0] OPC_OR   = 8'h11;
    localparam logic [OPW-1:0] OPC_AND  = 8'h12;
    localparam logic [OPW-1:0] OPC_XOR  = 8'h13;
    localparam logic [OPW-1:0] OPC_SHL  = 8'h15;
    localparam logic [OPW-1:0] OPC_SHR  = 8'h16;
    localparam logic [OPW-1:0] OPC_SUB  = 8'h17;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_MUL,
        OP_DIV,
        OP_DIVR,
        OP_MOD,
        OP_MODR,
        OP_GT,
        OP_EQ,
        OP_NOT,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_SHL,
        OP_SHR,
        OP_BAD
    } alu_kind_e;

    typedef enum logic [1:0] {
        ENG_SUMPROD,
        ENG_DIVIDE,
        ENG_LOGIC,
        ENG_NONE
    } alu_engine_e;

endpackage

// File: rtl/tri_alu_decode.sv
module tri_alu_decode
    import tri_alu_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output alu_kind_e      kind,
    output alu_engine_e    engine,
    output logic           illegal
);

    always_comb begin
        kind = OP_BAD;
        unique case (opcode)
            OPC_ADD:  kind = OP_ADD;
            OPC_SUB:  kind = OP_SUB;
            OPC_MUL:  kind = OP_MUL;
            OPC_DIV:  kind = OP_DIV;
            OPC_DIVR: kind = OP_DIVR;
            OPC_MOD:  kind = OP_MOD;
            OPC_MODR: kind = OP_MODR;
            OPC_GT:   kind = OP_GT;
            OPC_EQ:   kind = OP_EQ;
            OPC_NOT:  kind = OP_NOT;
            OPC_OR:   kind = OP_OR;
            OPC_AND:  kind = OP_AND;
            OPC_XOR:  kind = OP_XOR;
            OPC_SHL:  kind = OP_SHL;
            OPC_SHR:  kind = OP_SHR;
            default:  kind = OP_BAD;
        endcase
    end

    always_comb begin
        engine  = ENG_NONE;
        illegal = 1'b0;
        unique case (kind)
            OP_ADD, OP_SUB, OP_MUL:
                engine = ENG_SUMPROD;
            OP_DIV, OP_DIVR, OP_MOD, OP_MODR:
                engine = ENG_DIVIDE;
            OP_GT, OP_EQ, OP_NOT, OP_OR, OP_AND, OP_XOR, OP_SHL, OP_SHR:
                engine = ENG_LOGIC;
            OP_BAD: begin
                engine  = ENG_NONE;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tri_alu_sumprod.sv
module tri_alu_sumprod
    import tri_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_kind_e        kind,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [XLEN-1:0]  imm,
    input  logic [XLEN-1:0]  b_plus_imm,
    output logic [XLEN-1:0]  value
);

    logic [XLEN-1:0] prod_ab;
    logic [XLEN-1:0] prod_abi;
    logic [XLEN-1:0] sum_val;
    logic [XLEN-1:0] diff_val;

    // Low bits of a product do not depend on operand signedness.
    assign prod_ab  = src_a * src_b;
    assign prod_abi = prod_ab * imm;
    assign sum_val  = src_a + b_plus_imm;
    assign diff_val = src_a - b_plus_imm;

    always_comb begin
        unique case (kind)
            OP_ADD:  value = sum_val;
            OP_SUB:  value = diff_val;
            OP_MUL:  value = prod_abi;
            default: value = '0;
        endcase
    end

endmodule

// File: rtl/tri_alu_divider.sv
module tri_alu_divider
    import tri_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_kind_e        kind,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  imm,
    input  logic [XLEN-1:0]  b_plus_imm,
    output logic [XLEN-1:0]  value,
    output logic             zero_div
);

    logic [XLEN-1:0] dividend;
    logic [XLEN-1:0] divisor;
    logic            reversed;
    logic            want_rem;
    logic            neg_n;
    logic            neg_d;
    logic [XLEN-1:0] mag_n;
    logic [XLEN-1:0] mag_d;
    logic [XLEN-1:0] safe_d;
    logic [XLEN-1:0] uquo;
    logic [XLEN-1:0] urem;
    logic [XLEN-1:0] squo;
    logic [XLEN-1:0] srem;

    assign reversed = (kind == OP_DIVR) || (kind == OP_MODR);
    assign want_rem = (kind == OP_MOD)  || (kind == OP_MODR);

    assign dividend = reversed ? imm   : src_a;
    assign divisor  = reversed ? src_a : b_plus_imm;

    assign neg_n = dividend[XLEN-1];
    assign neg_d = divisor[XLEN-1];

    // Magnitudes as unsigned values; the most negative number maps to itself,
    // which is its correct unsigned magnitude.
    assign mag_n  = neg_n ? (~dividend + 1'b1) : dividend;
    assign mag_d  = neg_d ? (~divisor + 1'b1)  : divisor;
    assign safe_d = (divisor == '0) ? {{(XLEN-1){1'b0}}, 1'b1} : mag_d;

    assign uquo = mag_n / safe_d;
    assign urem = mag_n % safe_d;

    assign squo = (neg_n ^ neg_d) ? (~uquo + 1'b1) : uquo;
    assign srem = neg_n ? (~urem + 1'b1) : urem;

    always_comb begin
        zero_div = 1'b0;
        value    = '0;
        unique case (kind)
            OP_DIV, OP_DIVR, OP_MOD, OP_MODR: begin
                if (divisor == '0) begin
                    zero_div = 1'b1;
                    value    = '0;
                end else begin
                    value = want_rem ? srem : squo;
                end
            end
            default: begin
                zero_div = 1'b0;
                value    = '0;
            end
        endcase
    end

endmodule

// File: rtl/tri_alu_logic.sv
module tri_alu_logic
    import tri_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_kind_e        kind,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [XLEN-1:0]  imm,
    input  logic [XLEN-1:0]  b_plus_imm,
    output logic [XLEN-1:0]  value
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] shl_val;
    logic [XLEN-1:0] shr_val;
    logic            gt_bit;
    logic            eq_bit;

    assign shamt   = b_plus_imm[SHW-1:0];
    assign shl_val = src_a << shamt;
    assign shr_val = $signed(src_a) >>> shamt;
    assign gt_bit  = $signed(src_a) > $signed(src_b);
    assign eq_bit  = (src_a == src_b);

    always_comb begin
        unique case (kind)
            OP_GT:   value = {{(XLEN-1){1'b0}}, gt_bit};
            OP_EQ:   value = {{(XLEN-1){1'b0}}, eq_bit};
            OP_NOT:  value = ~src_a;
            OP_OR:   value = src_a | src_b | imm;
            OP_AND:  value = src_a & src_b;
            OP_XOR:  value = src_a ^ b_plus_imm;
            OP_SHL:  value = shl_val;
            OP_SHR:  value = shr_val;
            default: value = '0;
        endcase
    end

endmodule

// File: rtl/tri_alu.sv
module tri_alu
    import tri_alu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPW-1:0]   opcode,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [XLEN-1:0]  imm,
    output logic [XLEN-1:0]  result,
    output logic             div_zero,
    output logic             bad_op
);

    alu_kind_e       kind;
    alu_engine_e     engine;
    logic            illegal;
    logic [XLEN-1:0] b_plus_imm;
    logic [XLEN-1:0] sp_val;
    logic [XLEN-1:0] dv_val;
    logic [XLEN-1:0] lg_val;
    logic            dv_zero;

    logic [XLEN-1:0] res_c;
    logic            dz_c;
    logic            bad_c;

    // Shared folded operand: second register plus immediate.
    assign b_plus_imm = src_b + imm;

    tri_alu_decode u_decode (
        .opcode  (opcode),
        .kind    (kind),
        .engine  (engine),
        .illegal (illegal)
    );

    tri_alu_sumprod #(.XLEN(XLEN)) u_sumprod (
        .kind       (kind),
        .src_a      (src_a),
        .src_b      (src_b),
        .imm        (imm),
        .b_plus_imm (b_plus_imm),
        .value      (sp_val)
    );

    tri_alu_divider #(.XLEN(XLEN)) u_divider (
        .kind       (kind),
        .src_a      (src_a),
        .imm        (imm),
        .b_plus_imm (b_plus_imm),
        .value      (dv_val),
        .zero_div   (dv_zero)
    );

    tri_alu_logic #(.XLEN(XLEN)) u_logic (
        .kind       (kind),
        .src_a      (src_a),
        .src_b      (src_b),
        .imm        (imm),
        .b_plus_imm (b_plus_imm),
        .value      (lg_val)
    );

    always_comb begin
        res_c = '0;
        dz_c  = 1'b0;
        bad_c = 1'b0;
        unique case (engine)
            ENG_SUMPROD: res_c = sp_val;
            ENG_DIVIDE: begin
                res_c = dv_val;
                dz_c  = dv_zero;
            end
            ENG_LOGIC:   res_c = lg_val;
            ENG_NONE: begin
                res_c = '0;
                bad_c = illegal;
            end
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg_out
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result   <= '0;
                    div_zero <= 1'b0;
                    bad_op   <= 1'b0;
                end else begin
                    result   <= res_c;
                    div_zero <= dz_c;
                    bad_op   <= bad_c;
                end
            end
        end else begin : g_comb_out
            assign result   = res_c;
            assign div_zero = dz_c;
            assign bad_op   = bad_c;
        end
    endgenerate

endmodule

// File: rtl/tri_alu_checker.sv
module tri_alu_checker #(
    parameter int XLEN    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      opcode,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [XLEN-1:0] result,
    input logic            div_zero,
    input logic            bad_op
);

    logic [7:0]      op_q;
    logic [XLEN-1:0] a_q;
    logic [XLEN-1:0] b_q;
    logic            primed;
    logic [7:0]      out_op;
    logic [XLEN-1:0] out_a;
    logic [XLEN-1:0] out_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            primed <= 1'b0;
        end else begin
            op_q   <= opcode;
            a_q    <= src_a;
            b_q    <= src_b;
            primed <= 1'b1;
        end
    end

    assign out_op = REG_OUT ? op_q : opcode;
    assign out_a  = REG_OUT ? a_q  : src_a;
    assign out_b  = REG_OUT ? b_q  : src_b;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        !(div_zero && bad_op)); // R12

    AST_BAD_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        bad_op |-> (result == '0)); // R10

    AST_DZ_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        div_zero |-> (result == '0)); // R6

    AST_DZ_ONLY_DIVIDE: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        div_zero |-> (out_op inside {8'h04, 8'h05, 8'h06, 8'h07})); // R6

    AST_CMP_IS_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (out_op == 8'h0e || out_op == 8'h0f) |-> (result[XLEN-1:1] == '0)); // R7

    AST_EQ_OF_SAME: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (out_op == 8'h0f && out_a == out_b) |-> (result == {{(XLEN-1){1'b0}}, 1'b1})); // R7

endmodule

bind tri_alu tri_alu_checker #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .src_a    (src_a),
    .src_b    (src_b),
    .result   (result),
    .div_zero (div_zero),
    .bad_op   (bad_op)
);

// File: tb/tb_tri_alu.sv
module tb_tri_alu;

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] imm;
        logic [31:0] res;
        logic        dz;
        logic        bad;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;

    localparam vec_t VECS [NV] = '{
        '{8'h02, 32'd5,          32'd7,          32'd100,        32'h0000_0070, 1'b0, 1'b0, 8'd1},  // R1
        '{8'h02, 32'h7FFF_FFFF,  32'd1,          32'd0,          32'h8000_0000, 1'b0, 1'b0, 8'd1},  // R1 wrap
        '{8'h17, 32'd10,         32'd3,          32'd4,          32'd3,         1'b0, 1'b0, 8'd2},  // R2
        '{8'h17, 32'd0,          32'd1,          32'd0,          32'hFFFF_FFFF, 1'b0, 1'b0, 8'd2},  // R2
        '{8'h03, 32'd3,          32'hFFFF_FFFC,  32'd5,          32'hFFFF_FFC4, 1'b0, 1'b0, 8'd3},  // R3
        '{8'h03, 32'h0001_2345,  32'h100,        32'h100,        32'h2345_0000, 1'b0, 1'b0, 8'd3},  // R3 truncation
        '{8'h04, 32'hFFFF_FFF9,  32'd1,          32'd1,          32'hFFFF_FFFD, 1'b0, 1'b0, 8'd4},  // R4 -7/2
        '{8'h04, 32'h8000_0000,  32'hFFFF_FFFF,  32'd0,          32'h8000_0000, 1'b0, 1'b0, 8'd4},  // R4 min/-1
        '{8'h05, 32'd3,          32'd99,         32'd20,         32'd6,         1'b0, 1'b0, 8'd4},  // R4 reversed
        '{8'h06, 32'hFFFF_FFF9,  32'd2,          32'd1,          32'hFFFF_FFFF, 1'b0, 1'b0, 8'd5},  // R5 -7%3
        '{8'h07, 32'hFFFF_FFFC,  32'd0,          32'd10,         32'd2,         1'b0, 1'b0, 8'd5},  // R5 10%-4
        '{8'h04, 32'd5,          32'd3,          32'hFFFF_FFFD,  32'd0,         1'b1, 1'b0, 8'd6},  // R6
        '{8'h07, 32'd0,          32'd4,          32'd9,          32'd0,         1'b1, 1'b0, 8'd6},  // R6
        '{8'h0e, 32'hFFFF_FFFF,  32'd1,          32'd0,          32'd0,         1'b0, 1'b0, 8'd7},  // R7
        '{8'h0e, 32'd2,          32'hFFFF_FFFE,  32'd0,          32'd1,         1'b0, 1'b0, 8'd7},  // R7
        '{8'h0f, 32'h55,         32'h55,         32'd7,          32'd1,         1'b0, 1'b0, 8'd7},  // R7
        '{8'h10, 32'h0F0F_0000,  32'd0,          32'h1234,       32'hF0F0_FFFF, 1'b0, 1'b0, 8'd8},  // R8
        '{8'h11, 32'd1,          32'd2,          32'h100,        32'h0000_0103, 1'b0, 1'b0, 8'd8},  // R8
        '{8'h12, 32'hFF00_FF00,  32'h0FF0_0FF0,  32'hFFFF_FFFF,  32'h0F00_0F00, 1'b0, 1'b0, 8'd8},  // R8 imm ignored
        '{8'h13, 32'hFFFF_0000,  32'h0F,         32'd1,          32'hFFFF_0010, 1'b0, 1'b0, 8'd8},  // R8
        '{8'h15, 32'd1,          32'd30,         32'd2,          32'd1,         1'b0, 1'b0, 8'd9},  // R9 amount 32 -> 0
        '{8'h15, 32'd3,          32'd4,          32'd0,          32'h30,        1'b0, 1'b0, 8'd9},  // R9
        '{8'h16, 32'h8000_0000,  32'd3,          32'd1,          32'hF800_0000, 1'b0, 1'b0, 8'd9},  // R9 sign fill
        '{8'h16, 32'h40,         32'd0,          32'h26,         32'd1,         1'b0, 1'b0, 8'd9},  // R9 low bits
        '{8'h00, 32'd5,          32'd5,          32'd5,          32'd0,         1'b0, 1'b1, 8'd10}, // R10
        '{8'hFF, 32'd9,          32'd1,          32'd1,          32'd0,         1'b0, 1'b1, 8'd10}, // R10
        '{8'h01, 32'd7,          32'd7,          32'd7,          32'd0,         1'b0, 1'b1, 8'd10}  // R10
    };

    logic        clk;
    logic        rst_n;
    logic [7:0]  opcode;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic [31:0] imm;
    logic [31:0] result;
    logic        div_zero;
    logic        bad_op;

    int checks;
    int fails;
    bit done;

    tri_alu dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .src_a    (src_a),
        .src_b    (src_b),
        .imm      (imm),
        .result   (result),
        .div_zero (div_zero),
        .bad_op   (bad_op)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check_out(input string req, input logic [31:0] er,
                             input logic edz, input logic ebad);
        checks++;
        if (result !== er || div_zero !== edz || bad_op !== ebad) begin
            fails++;
            $display("FAIL %s: result=%h dz=%b bad=%b expected result=%h dz=%b bad=%b",
                     req, result, div_zero, bad_op, er, edz, ebad);
        end
    endtask

    task automatic drive(input logic [7:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] im);
        opcode = op;
        src_a  = a;
        src_b  = b;
        imm    = im;
    endtask

    initial begin
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        drive(8'h02, 32'd1, 32'd2, 32'd3);
        #1;
        // R11: reset state with a legal nonzero operation applied
        check_out("R11 reset", 32'd0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check_out("R11 held in reset", 32'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm);
            @(negedge clk);
            check_out($sformatf("R%0d vec %0d", VECS[i].req, i),
                      VECS[i].res, VECS[i].dz, VECS[i].bad);
            checks++;
            if (div_zero && bad_op) begin
                fails++;
                $display("FAIL R12 vec %0d: dz=%b bad=%b expected not both", i, div_zero, bad_op);
            end
        end

        // R11: latency; last vector left result 0, bad 1
        @(negedge clk);
        drive(8'h02, 32'd1, 32'd1, 32'd1);
        #1;
        check_out("R11 before edge", 32'd0, 1'b0, 1'b1);
        @(negedge clk);
        check_out("R11 after edge", 32'd3, 1'b0, 1'b0);

        // R6: divide-by-zero flag clears on the next legal operation
        drive(8'h06, 32'd9, 32'd0, 32'd0);
        @(negedge clk);
        check_out("R6 mod by zero", 32'd0, 1'b1, 1'b0);
        drive(8'h06, 32'd9, 32'd0, 32'd4);
        @(negedge clk);
        check_out("R5 9%4", 32'd1, 1'b0, 1'b0);

        // R11: asynchronous reset mid-run
        drive(8'h11, 32'hF, 32'hF0, 32'h0);
        @(negedge clk);
        check_out("R8 or", 32'hFF, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        check_out("R11 async clear", 32'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R11 resume", 32'hFF, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule